// File: doc/BRIEF.md
# Two-Thread Group Completion Table

This block follows instruction groups of a two-thread core from the moment they are dispatched until they retire. Each dispatched group takes one slot of a single shared table. The slot index is handed back to dispatch as the group's tag. Groups of both threads may sit side by side in any slot order. Execution units report finished instructions by tag and by the position of the instruction inside its group. They report in any order, and a report may carry an exception mark.

Every thread keeps its own retirement order through a per-thread sequence number stored in each slot. The oldest live group of a thread retires once all of its instructions have finished cleanly. The two threads retire independently, so two groups (one per thread) can retire in the same cycle. If the oldest group of a thread holds an exception, the block raises a flush request for that thread. It then drops every slot of that thread at the next edge and leaves the other thread's slots intact. A full indication stalls dispatch while no slot is free. The table is shared dynamically, so a single running thread can fill all of it.

Top module: `grp_cmpl_tbl`

## Requirements
- R1: After reset no commit and no flush is signalled, `tbl_full` is low, and the first dispatched group receives tag 0.
- R2: `disp_tag` always shows the lowest-numbered free slot. A dispatch accepted at an edge occupies exactly that slot.
- R3: A group dispatched with count N (1 to 5) commits only after finish reports have arrived for all instruction positions 0 to N-1, in any order. Its commit event is visible in the cycle after the edge that captured the last report.
- R4: Within one thread, groups commit in dispatch order. A younger group that is fully finished waits until every older group of its thread has committed, and it commits in the cycle after the edge that frees the older one.
- R5: At most one group per thread commits per cycle. When the oldest groups of both threads are ready in the same cycle, both commit events appear together with their two tags.
- R6: A committed slot becomes free at the edge that ends its commit cycle. `tbl_full` is high exactly while all 20 slots are live. A dispatch presented while `tbl_full` is high is ignored and does not disturb any live slot.
- R7: When the oldest live group of a thread carries an exception, `flush_req` for that thread is high for one cycle and no commit is signalled for that thread. At the next edge all of that thread's slots are freed. A dispatch for that thread presented in the same cycle is dropped. The other thread's slots and commits are unaffected.
- R8: A single thread may occupy all 20 slots. After a flush, the first new group of the flushed thread is that thread's oldest group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_vld | input | 1 | Dispatch request for one group |
| disp_thr | input | 1 | Thread of the dispatched group (0 or 1) |
| disp_cnt | input | 3 | Number of instructions in the group, 1 to 5 |
| disp_tag | output | 5 | Tag (slot index) the dispatched group receives |
| tbl_full | output | 1 | No free slot; dispatch must stall |
| fin_vld | input | 2 | Finish report valid, one bit per report port |
| fin_tag | input | 10 | Group tag per report port (port p in bits 5p+4..5p) |
| fin_slot | input | 6 | Instruction position in the group, 0 to 4 (port p in bits 3p+2..3p) |
| fin_exc | input | 2 | Finished instruction raised an exception, per port |
| cmt_vld | output | 2 | Commit event, bit t for thread t |
| cmt_tag | output | 10 | Tag of the committing group of thread t in bits 5t+4..5t |
| flush_req | output | 2 | Exception flush request, bit t for thread t |

## Verification
The bench targets the cases where per-thread order and the shared table interact. A finished younger group must sit behind an unfinished older one, or a design that ignores age retires it out of order. Both threads must become ready in the same cycle, or a design with a single retire port loses one event. An exception must be caught while another thread's group and a same-thread dispatch are in flight, or the design either wipes the wrong thread or lets the dropped group become a phantom oldest entry that blocks later commits. Finally, the table is filled from one thread and then offered one more dispatch. A design that overwrites a live slot then fails to retire the overwritten group.

// File: rtl/gct_pkg.sv
package gct_pkg;
  localparam int GCT_NTHR  = 2;
  localparam int GCT_DEPTH = 20;
  localparam int GCT_GMAX  = 5;
  localparam int GCT_NFIN  = 2;
endpackage

// File: rtl/gct_pick.sv
module gct_pick #(
  parameter int W  = 8,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/gct_entry.sv
module gct_entry #(
  parameter int IDX   = 0,
  parameter int GMAX  = 5,
  parameter int NFIN  = 2,
  parameter int TAGW  = 5,
  parameter int SEQW  = 6,
  parameter int CNTW  = 3,
  parameter int SLOTW = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_i,
  input  logic               alloc_thr_i,
  input  logic [CNTW-1:0]    alloc_cnt_i,
  input  logic [SEQW-1:0]    alloc_seq_i,
  input  logic [NFIN-1:0]    fin_vld_i,
  input  logic [NFIN*TAGW-1:0]  fin_tag_i,
  input  logic [NFIN*SLOTW-1:0] fin_slot_i,
  input  logic [NFIN-1:0]    fin_exc_i,
  input  logic               kill_i,
  output logic               vld_o,
  output logic               thr_o,
  output logic [SEQW-1:0]    seq_o,
  output logic               done_o,
  output logic               exc_o
);
  logic            vld_q, vld_n;
  logic            thr_q, thr_n;
  logic [SEQW-1:0] seq_q, seq_n;
  logic [GMAX-1:0] msk_q, msk_n;
  logic            exc_q, exc_n;
  logic            hit;
  logic            en;

  always_comb begin
    hit = 1'b0;
    for (int p = 0; p < NFIN; p++) begin
      if (fin_vld_i[p] && fin_tag_i[p*TAGW +: TAGW] == TAGW'(IDX)) hit = 1'b1;
    end
  end

  assign en = kill_i | alloc_i | (hit & vld_q);

  always_comb begin
    vld_n = vld_q;
    thr_n = thr_q;
    seq_n = seq_q;
    msk_n = msk_q;
    exc_n = exc_q;
    if (kill_i) begin
      vld_n = 1'b0;
    end else if (alloc_i) begin
      vld_n = 1'b1;
      thr_n = alloc_thr_i;
      seq_n = alloc_seq_i;
      exc_n = 1'b0;
      for (int s = 0; s < GMAX; s++) msk_n[s] = (s >= int'(alloc_cnt_i));
    end else if (vld_q) begin
      for (int p = 0; p < NFIN; p++) begin
        if (fin_vld_i[p] && fin_tag_i[p*TAGW +: TAGW] == TAGW'(IDX)) begin
          if (int'(fin_slot_i[p*SLOTW +: SLOTW]) < GMAX)
            msk_n[fin_slot_i[p*SLOTW +: SLOTW]] = 1'b1;
          exc_n = exc_n | fin_exc_i[p];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      thr_q <= 1'b0;
      seq_q <= '0;
      msk_q <= '0;
      exc_q <= 1'b0;
    end else if (en) begin
      vld_q <= vld_n;
      thr_q <= thr_n;
      seq_q <= seq_n;
      msk_q <= msk_n;
      exc_q <= exc_n;
    end
  end

  assign vld_o  = vld_q;
  assign thr_o  = thr_q;
  assign seq_o  = seq_q;
  assign done_o = &msk_q;
  assign exc_o  = exc_q;
endmodule

// File: rtl/grp_cmpl_tbl.sv
module grp_cmpl_tbl #(
  parameter int DEPTH = gct_pkg::GCT_DEPTH,
  parameter int GMAX  = gct_pkg::GCT_GMAX,
  parameter int NFIN  = gct_pkg::GCT_NFIN,
  parameter int NTHR  = gct_pkg::GCT_NTHR,
  parameter int TAGW  = $clog2(DEPTH),
  parameter int CNTW  = $clog2(GMAX + 1),
  parameter int SLOTW = $clog2(GMAX)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   disp_vld,
  input  logic                   disp_thr,
  input  logic [CNTW-1:0]        disp_cnt,
  output logic [TAGW-1:0]        disp_tag,
  output logic                   tbl_full,
  input  logic [NFIN-1:0]        fin_vld,
  input  logic [NFIN*TAGW-1:0]   fin_tag,
  input  logic [NFIN*SLOTW-1:0]  fin_slot,
  input  logic [NFIN-1:0]        fin_exc,
  output logic [NTHR-1:0]        cmt_vld,
  output logic [NTHR*TAGW-1:0]   cmt_tag,
  output logic [NTHR-1:0]        flush_req
);
  localparam int SEQW = TAGW + 1;

  logic [DEPTH-1:0] ent_vld, ent_thr, ent_done, ent_exc;
  logic [DEPTH-1:0] ent_alloc, ent_kill;
  logic [SEQW-1:0]  ent_seq [DEPTH];

  logic [SEQW-1:0]  head_q [NTHR];
  logic [SEQW-1:0]  head_n [NTHR];
  logic [SEQW-1:0]  tail_q [NTHR];
  logic [SEQW-1:0]  tail_n [NTHR];
  logic [NTHR-1:0]  ptr_en;

  logic [DEPTH-1:0] match_v [NTHR];
  logic [NTHR-1:0]  old_vld;
  logic [TAGW-1:0]  old_idx [NTHR];

  logic             has_free;
  logic [TAGW-1:0]  free_idx;
  logic             alloc_go;

  // free slot selection
  gct_pick #(.W(DEPTH), .IW(TAGW)) i_free_pick (
    .req (~ent_vld),
    .any (has_free),
    .idx (free_idx)
  );

  assign disp_tag = free_idx;
  assign tbl_full = ~has_free;
  assign alloc_go = disp_vld & has_free & ~flush_req[disp_thr];

  // per-thread oldest group, commit and flush
  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    always_comb begin
      for (int i = 0; i < DEPTH; i++)
        match_v[t][i] = ent_vld[i] && (ent_thr[i] == 1'(t)) && (ent_seq[i] == head_q[t]);
    end

    gct_pick #(.W(DEPTH), .IW(TAGW)) i_old_pick (
      .req (match_v[t]),
      .any (old_vld[t]),
      .idx (old_idx[t])
    );

    assign cmt_vld[t]   = old_vld[t] & ent_done[old_idx[t]] & ~ent_exc[old_idx[t]];
    assign flush_req[t] = old_vld[t] & ent_exc[old_idx[t]];
    assign cmt_tag[t*TAGW +: TAGW] = old_idx[t];

    always_comb begin
      head_n[t] = head_q[t] + SEQW'(cmt_vld[t]);
      if (flush_req[t]) tail_n[t] = head_q[t];
      else              tail_n[t] = tail_q[t] + SEQW'(alloc_go && (disp_thr == 1'(t)));
      ptr_en[t] = cmt_vld[t] | flush_req[t] | (alloc_go && (disp_thr == 1'(t)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        head_q[t] <= '0;
        tail_q[t] <= '0;
      end else if (ptr_en[t]) begin
        head_q[t] <= head_n[t];
        tail_q[t] <= tail_n[t];
      end
    end
  end

  // table slots
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_comb begin
      ent_alloc[i] = alloc_go && (free_idx == TAGW'(i));
      ent_kill[i]  = ent_vld[i] &&
                     (flush_req[ent_thr[i]] ||
                      (cmt_vld[ent_thr[i]] && (old_idx[ent_thr[i]] == TAGW'(i))));
    end

    gct_entry #(
      .IDX(i), .GMAX(GMAX), .NFIN(NFIN), .TAGW(TAGW),
      .SEQW(SEQW), .CNTW(CNTW), .SLOTW(SLOTW)
    ) i_ent (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_i     (ent_alloc[i]),
      .alloc_thr_i (disp_thr),
      .alloc_cnt_i (disp_cnt),
      .alloc_seq_i (tail_q[disp_thr]),
      .fin_vld_i   (fin_vld),
      .fin_tag_i   (fin_tag),
      .fin_slot_i  (fin_slot),
      .fin_exc_i   (fin_exc),
      .kill_i      (ent_kill[i]),
      .vld_o       (ent_vld[i]),
      .thr_o       (ent_thr[i]),
      .seq_o       (ent_seq[i]),
      .done_o      (ent_done[i]),
      .exc_o       (ent_exc[i])
    );
  end
endmodule

// File: rtl/gct_chk.sv
module gct_chk #(
  parameter int TAGW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tbl_full,
  input logic [1:0]        cmt_vld,
  input logic [2*TAGW-1:0] cmt_tag,
  input logic [1:0]        flush_req
);
  assert_cmt_flush_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_vld & flush_req) == 2'b00);

  assert_flush_pulse0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req[0] |=> (!flush_req[0] && !cmt_vld[0]));

  assert_flush_pulse1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req[1] |=> (!flush_req[1] && !cmt_vld[1]));

  assert_no_recommit0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_vld[0] |=> !(cmt_vld[0] && cmt_tag[TAGW-1:0] == $past(cmt_tag[TAGW-1:0])));

  assert_no_recommit1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_vld[1] |=> !(cmt_vld[1] && cmt_tag[2*TAGW-1:TAGW] == $past(cmt_tag[2*TAGW-1:TAGW])));

  assert_dual_tags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (&cmt_vld) |-> (cmt_tag[TAGW-1:0] != cmt_tag[2*TAGW-1:TAGW]));

  assert_full_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_full && cmt_vld == 2'b00 && flush_req == 2'b00) |=> tbl_full);
endmodule

bind grp_cmpl_tbl gct_chk #(.TAGW(TAGW)) i_gct_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tbl_full  (tbl_full),
  .cmt_vld   (cmt_vld),
  .cmt_tag   (cmt_tag),
  .flush_req (flush_req)
);

// File: tb/test_grp_cmpl_tbl.sv
`timescale 1ns/1ps
module test_grp_cmpl_tbl;
  logic       clk;
  logic       rst_n;
  logic       disp_vld;
  logic       disp_thr;
  logic [2:0] disp_cnt;
  logic [4:0] disp_tag;
  logic       tbl_full;
  logic [1:0] fin_vld;
  logic [9:0] fin_tag;
  logic [5:0] fin_slot;
  logic [1:0] fin_exc;
  logic [1:0] cmt_vld;
  logic [9:0] cmt_tag;
  logic [1:0] flush_req;

  int errors = 0;
  int checks = 0;
  bit done_flag = 0;

  grp_cmpl_tbl i_grp_cmpl_tbl (
    .clk(clk), .rst_n(rst_n), .disp_vld(disp_vld), .disp_thr(disp_thr),
    .disp_cnt(disp_cnt), .disp_tag(disp_tag), .tbl_full(tbl_full),
    .fin_vld(fin_vld), .fin_tag(fin_tag), .fin_slot(fin_slot), .fin_exc(fin_exc),
    .cmt_vld(cmt_vld), .cmt_tag(cmt_tag), .flush_req(flush_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic       dv;
    logic       dthr;
    logic [2:0] dcnt;
    logic [4:0] etag;
    logic       fv;
    logic [4:0] ftag;
    logic [2:0] fslot;
    logic       fexc;
    logic [1:0] ecmt;
    logic [4:0] et0;
    logic [4:0] et1;
    logic [1:0] efl;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1,1'b0,3'd2,5'd0, 1'b0,5'd0,3'd0,1'b0, 2'b00,5'd0,5'd0,2'b00},
    '{1'b1,1'b1,3'd1,5'd1, 1'b0,5'd0,3'd0,1'b0, 2'b00,5'd0,5'd0,2'b00},
    '{1'b1,1'b0,3'd1,5'd2, 1'b1,5'd1,3'd0,1'b0, 2'b10,5'd0,5'd1,2'b00},
    '{1'b0,1'b0,3'd0,5'd0, 1'b1,5'd2,3'd0,1'b0, 2'b00,5'd0,5'd0,2'b00},
    '{1'b0,1'b0,3'd0,5'd0, 1'b1,5'd0,3'd1,1'b0, 2'b00,5'd0,5'd0,2'b00},
    '{1'b0,1'b0,3'd0,5'd0, 1'b1,5'd0,3'd0,1'b0, 2'b01,5'd0,5'd0,2'b00},
    '{1'b0,1'b0,3'd0,5'd0, 1'b0,5'd0,3'd0,1'b0, 2'b01,5'd2,5'd0,2'b00},
    '{1'b1,1'b1,3'd3,5'd0, 1'b0,5'd0,3'd0,1'b0, 2'b00,5'd0,5'd0,2'b00},
    '{1'b1,1'b0,3'd1,5'd1, 1'b1,5'd0,3'd2,1'b1, 2'b00,5'd0,5'd0,2'b10},
    '{1'b1,1'b1,3'd1,5'd2, 1'b1,5'd1,3'd0,1'b0, 2'b01,5'd1,5'd0,2'b00},
    '{1'b1,1'b1,3'd1,5'd0, 1'b0,5'd0,3'd0,1'b0, 2'b00,5'd0,5'd0,2'b00},
    '{1'b0,1'b0,3'd0,5'd0, 1'b1,5'd0,3'd0,1'b0, 2'b10,5'd0,5'd0,2'b00},
    '{1'b1,1'b0,3'd1,5'd1, 1'b0,5'd0,3'd0,1'b0, 2'b00,5'd0,5'd0,2'b00},
    '{1'b1,1'b1,3'd1,5'd0, 1'b0,5'd0,3'd0,1'b0, 2'b00,5'd0,5'd0,2'b00},
    '{1'b0,1'b0,3'd0,5'd0, 1'b1,5'd1,3'd0,1'b0, 2'b01,5'd1,5'd0,2'b00},
    '{1'b0,1'b0,3'd0,5'd0, 1'b1,5'd0,3'd0,1'b0, 2'b10,5'd0,5'd0,2'b00}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_in();
    disp_vld = 1'b0; disp_thr = 1'b0; disp_cnt = 3'd0;
    fin_vld = 2'b00; fin_tag = '0; fin_slot = '0; fin_exc = 2'b00;
  endtask

  task automatic do_reset();
    idle_in();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic disp(input logic thr, input int cnt, input int exp_tag, input string req);
    idle_in();
    disp_vld = 1'b1; disp_thr = thr; disp_cnt = 3'(cnt);
    check(req, int'(disp_tag), exp_tag);
    cyc();
  endtask

  task automatic fin1(input int tag, input int slot, input logic exc);
    idle_in();
    fin_vld = 2'b01; fin_tag[4:0] = 5'(tag); fin_slot[2:0] = 3'(slot); fin_exc[0] = exc;
    cyc();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    int wd;
    wd = 0;
    while (!done_flag) begin
      @(posedge clk);
      wd++;
      if (wd > 20000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", wd, 20000);
        finish_run();
      end
    end
  end

  initial begin
    do_reset();
    @(negedge clk);

    // R1: reset state
    check("R1 full", int'(tbl_full), 0);
    check("R1 cmt", int'(cmt_vld), 0);
    check("R1 flush", int'(flush_req), 0);
    check("R1 tag", int'(disp_tag), 0);

    // vector table: R2 R3 R4 R6 R7
    for (int k = 0; k < NVEC; k++) begin
      idle_in();
      disp_vld = VEC[k].dv; disp_thr = VEC[k].dthr; disp_cnt = VEC[k].dcnt;
      fin_vld = {1'b0, VEC[k].fv}; fin_tag[4:0] = VEC[k].ftag;
      fin_slot[2:0] = VEC[k].fslot; fin_exc = {1'b0, VEC[k].fexc};
      if (VEC[k].dv) check($sformatf("R2 tag row %0d", k), int'(disp_tag), int'(VEC[k].etag));
      cyc();
      check($sformatf("R4 cmt row %0d", k), int'(cmt_vld), int'(VEC[k].ecmt));
      check($sformatf("R7 flush row %0d", k), int'(flush_req), int'(VEC[k].efl));
      if (VEC[k].ecmt[0] && cmt_vld[0])
        check($sformatf("R3 tag0 row %0d", k), int'(cmt_tag[4:0]), int'(VEC[k].et0));
      if (VEC[k].ecmt[1] && cmt_vld[1])
        check($sformatf("R3 tag1 row %0d", k), int'(cmt_tag[9:5]), int'(VEC[k].et1));
    end

    // R5: both threads commit in one cycle
    do_reset();
    @(negedge clk);
    disp(1'b0, 1, 0, "R5 tag a");
    disp(1'b1, 1, 1, "R5 tag b");
    idle_in();
    fin_vld = 2'b11; fin_tag = {5'd1, 5'd0}; fin_slot = 6'd0;
    cyc();
    idle_in();
    check("R5 dual cmt", int'(cmt_vld), 3);
    check("R5 tag t0", int'(cmt_tag[4:0]), 0);
    check("R5 tag t1", int'(cmt_tag[9:5]), 1);
    cyc();
    check("R5 after", int'(cmt_vld), 0);

    // R3: five-instruction group, reports out of order
    do_reset();
    @(negedge clk);
    disp(1'b1, 5, 0, "R3 tag");
    fin1(0, 4, 1'b0); check("R3 partial a", int'(cmt_vld), 0);
    fin1(0, 2, 1'b0); check("R3 partial b", int'(cmt_vld), 0);
    fin1(0, 0, 1'b0); check("R3 partial c", int'(cmt_vld), 0);
    fin1(0, 3, 1'b0); check("R3 partial d", int'(cmt_vld), 0);
    fin1(0, 1, 1'b0);
    check("R3 full group", int'(cmt_vld), 2);
    check("R3 full tag", int'(cmt_tag[9:5]), 0);

    // R7: flush of thread 0 leaves thread 1 intact
    do_reset();
    @(negedge clk);
    disp(1'b0, 1, 0, "R7 tag a");
    disp(1'b1, 1, 1, "R7 tag b");
    disp(1'b0, 1, 2, "R7 tag c");
    fin1(0, 0, 1'b1);
    check("R7 flush t0", int'(flush_req), 1);
    check("R7 no cmt", int'(cmt_vld), 0);
    idle_in(); cyc();
    check("R7 flush pulse", int'(flush_req), 0);
    fin1(1, 0, 1'b0);
    check("R7 other thread cmt", int'(cmt_vld), 2);
    check("R7 other thread tag", int'(cmt_tag[9:5]), 1);
    disp(1'b0, 1, 0, "R7 freed slot reuse");
    fin1(0, 0, 1'b0);
    check("R8 new oldest after flush", int'(cmt_vld), 1);

    // R6 R8: one thread fills the table
    do_reset();
    @(negedge clk);
    for (int i = 0; i < 20; i++) disp(1'b0, 1, i, "R8 fill tag");
    idle_in();
    check("R6 full", int'(tbl_full), 1);
    disp_vld = 1'b1; disp_thr = 1'b1; disp_cnt = 3'd1;
    cyc();
    check("R6 still full", int'(tbl_full), 1);
    fin1(19, 0, 1'b0);
    check("R4 youngest waits", int'(cmt_vld), 0);
    fin1(0, 0, 1'b0);
    check("R6 dropped dispatch ignored", int'(cmt_vld), 1);
    check("R6 cmt tag", int'(cmt_tag[4:0]), 0);
    check("R6 no t1 cmt", int'(cmt_vld[1]), 0);
    idle_in(); cyc();
    check("R6 slot freed", int'(tbl_full), 0);
    check("R2 free tag", int'(disp_tag), 0);

    done_flag = 1'b1;
    finish_run();
  end
endmodule